// File: doc/BRIEF.md
# Core Halt/Restart Debug Controller

This block sits on a debug bus beside a processor core and gives an external debugger run control over it. The debugger issues 32-bit register reads and writes. Through them it can ask the core to stop, ask it to resume, and see whether it is stopped or has resumed. It can also see why the core last entered debug state. Toward the core, the block drives a halt-request and a restart-request line. Each line is held until the core's halted indication confirms that the request has been carried out.

While the core is stopped, the debugger can pass it an instruction word through a one-entry instruction mailbox. It can also exchange data words with the core through two one-entry data mailboxes, one in each direction. An access lock comes up set after reset. While the lock is set, the debugger sees nothing and changes nothing except the lock itself and the two status words that report it.

Register map (byte offsets): 0x00 status/control, 0x04 run control, 0x08 lock access, 0x0C lock status, 0x10 power/reset status, 0x14 instruction mailbox, 0x18 core-to-host data (read), 0x1C host-to-core data (write). Unlisted offsets read zero and ignore writes.

Top module: `dbg_run_ctl`

## Requirements
- R1: After reset the lock is set, halt_req, restart_req, itr_valid, rx_full, tx_full and hdbg_en are 0. Once unlocked, the status word reads 0x0100_0002: instruction-done bit 24 = 1, restarted bit 1 = 1, and all other bits 0.
- R2: Writing zero to lock access clears the lock and writing any non-zero value sets it. The lock shows as bit 1 of lock status and as bit 5 of power/reset status, and both words stay readable while locked.
- R3: While locked, writes to every register other than lock access are ignored. Reads of every register other than the two lock-reporting words return zero, and a locked read of core-to-host data does not empty it.
- R4: Writing 1 to run-control bit 0 while the core is running raises halt_req, which stays high until core_halted is seen, then drops. Status bit 0 reads the core's halted state. A halt request written while the core is halted is ignored.
- R5: Status bits [5:2] hold the cause of the last debug entry. They read 0b0000 when the entry answered a halt request, and otherwise hold core_cause as sampled at entry (breakpoint 0b0001, synchronous watchpoint 0b1010).
- R6: Writing 1 to run-control bit 1 while halted raises restart_req and clears restarted (status bit 1). restart_req drops, and restarted is set, once the core leaves debug state. A restart written while running is ignored. Run control always reads zero.
- R7: Status bit 14 (halting debug enable, driven on hdbg_en) and bit 13 (instruction execution enable) are read/write. Writes to all other status bits are ignored.
- R8: An instruction-mailbox write is accepted only while halted, with bit 13 set and no instruction outstanding. On acceptance itr_valid rises with the word on itr_word and status bit 24 reads 0 until itr_ack. Any other such write is ignored and bit 24 stays 1.
- R9: A host-to-core data write fills rx_word and sets rx_full (status bit 30). rx_take empties the mailbox, and a write while it is full is ignored.
- R10: A tx_put pulse loads tx_data and sets tx_full (status bit 29). A host read of core-to-host data returns the word and empties the mailbox, and a put while it is full is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| core_halted | input | 1 | Core is in debug state |
| core_cause | input | 4 | Core-reported debug-entry cause |
| itr_ack | input | 1 | Core has executed the mailbox instruction |
| rx_take | input | 1 | Core consumes the host-to-core word |
| tx_put | input | 1 | Core writes a core-to-host word |
| tx_data | input | 32 | Core-to-host word |
| halt_req | output | 1 | Halt request to core |
| restart_req | output | 1 | Restart request to core |
| hdbg_en | output | 1 | Halting debug mode enabled |
| itr_valid | output | 1 | Instruction word pending for the core |
| itr_word | output | 32 | Instruction word |
| rx_full | output | 1 | Host-to-core word pending |
| rx_word | output | 32 | Host-to-core word |
| tx_full | output | 1 | Core-to-host word pending |

## Verification
The bench targets the requests that must be ignored. These are a halt while already halted, a restart while running, an instruction written while running, while disabled or while another is outstanding, and mailbox writes and puts while full. A design that accepted any of them would raise a request line, replace a stored word or clear the done bit. The bench also checks that a halt request overrides the core's own cause code: a design that latched core_cause unconditionally would report a breakpoint. It checks that a locked read of the core-to-host word neither returns data nor empties the mailbox. It checks that restarted is cleared on acceptance and only set after the core actually leaves debug state.

// File: rtl/dbg_run_pkg.sv
package dbg_run_pkg;
   // register byte offsets
   localparam logic [7:0] OFS_STATUS = 8'h00;
   localparam logic [7:0] OFS_RUNCTL = 8'h04;
   localparam logic [7:0] OFS_LKACC  = 8'h08;
   localparam logic [7:0] OFS_LKSTAT = 8'h0C;
   localparam logic [7:0] OFS_PWRSTAT = 8'h10;
   localparam logic [7:0] OFS_INSTR  = 8'h14;
   localparam logic [7:0] OFS_TXDATA = 8'h18;
   localparam logic [7:0] OFS_RXDATA = 8'h1C;

   // status/control bit positions
   localparam int unsigned ST_HALTED    = 0;
   localparam int unsigned ST_RESTARTED = 1;
   localparam int unsigned ST_CAUSE_LO  = 2;
   localparam int unsigned ST_INSTR_EN  = 13;
   localparam int unsigned ST_HDBG_EN   = 14;
   localparam int unsigned ST_INSTR_DONE = 24;
   localparam int unsigned ST_TX_FULL   = 29;
   localparam int unsigned ST_RX_FULL   = 30;
   localparam int unsigned LK_BIT_STAT  = 1;
   localparam int unsigned LK_BIT_PWR   = 5;
   localparam int unsigned RC_HALT      = 0;
   localparam int unsigned RC_RESTART   = 1;

   typedef enum logic [3:0] {
      SEL_STATUS, SEL_RUNCTL, SEL_LKACC, SEL_LKSTAT,
      SEL_PWRSTAT, SEL_INSTR, SEL_TXDATA, SEL_RXDATA, SEL_NONE
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
      reg_sel_e s;
      case (ofs)
         OFS_STATUS:  s = SEL_STATUS;
         OFS_RUNCTL:  s = SEL_RUNCTL;
         OFS_LKACC:   s = SEL_LKACC;
         OFS_LKSTAT:  s = SEL_LKSTAT;
         OFS_PWRSTAT: s = SEL_PWRSTAT;
         OFS_INSTR:   s = SEL_INSTR;
         OFS_TXDATA:  s = SEL_TXDATA;
         OFS_RXDATA:  s = SEL_RXDATA;
         default:     s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/dbg_os_lock.sv
module dbg_os_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_wr,
   input  logic acc_zero,
   output logic locked
);
   always_ff @(posedge clk) begin
      if (!rst_n)      locked <= 1'b1;
      else if (acc_wr) locked <= !acc_zero;
   end

   AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_zero) |=> !locked); // R2
   AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && !acc_zero) |=> locked); // R2
endmodule

// File: rtl/dbg_run_state.sv
module dbg_run_state #(
   parameter int unsigned CAUSE_W     = 4,
   parameter int unsigned SYNC_STAGES = 1,
   parameter logic [CAUSE_W-1:0] HALT_CAUSE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               halt_wr,
   input  logic               restart_wr,
   input  logic               core_halted,
   input  logic [CAUSE_W-1:0] core_cause,
   output logic               halted,
   output logic               restarted,
   output logic [CAUSE_W-1:0] cause,
   output logic               halt_req,
   output logic               restart_req
);
   initial begin
      assert (SYNC_STAGES >= 1 && SYNC_STAGES <= 4);
      assert (CAUSE_W >= 1);
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   enter_dbg;
   logic                   leave_dbg;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= core_halted;
         end
      end else begin : g_sync_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], core_halted};
         end
      end
   endgenerate

   assign halted    = sync_q[SYNC_STAGES-1];
   assign enter_dbg = halted && !prev_q;
   assign leave_dbg = !halted && prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= halted;
   end

   // halt request: accepted only while running
   always_ff @(posedge clk) begin
      if (!rst_n)
         halt_req <= 1'b0;
      else if (halted)
         halt_req <= 1'b0;
      else if (halt_wr)
         halt_req <= 1'b1;
   end

   // restart request: accepted only while halted
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         restart_req <= 1'b0;
         restarted   <= 1'b1;
      end else if (leave_dbg) begin
         restart_req <= 1'b0;
         restarted   <= 1'b1;
      end else if (restart_wr && halted && !restart_req) begin
         restart_req <= 1'b1;
         restarted   <= 1'b0;
      end
   end

   // cause of the most recent debug entry
   always_ff @(posedge clk) begin
      if (!rst_n)
         cause <= '0;
      else if (enter_dbg)
         cause <= halt_req ? HALT_CAUSE : core_cause;
   end

   AST_HALT_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && halt_req) |=> !halt_req); // R4
   AST_RESTART_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart_req) |-> $past(halted)); // R6
   AST_RESTARTED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart_req) |-> !restarted); // R6
   AST_HALT_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_req) |-> !$past(halted)); // R4
endmodule

// File: rtl/dbg_xfer.sv
module dbg_xfer #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              itr_wr,
   input  logic              itr_allowed,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              itr_ack,
   input  logic              rx_wr,
   input  logic              rx_take,
   input  logic              tx_put,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_rd,
   output logic              itr_valid,
   output logic [DATA_W-1:0] itr_word,
   output logic              rx_full,
   output logic [DATA_W-1:0] rx_word,
   output logic              tx_full,
   output logic [DATA_W-1:0] tx_word
);
   logic itr_accept;
   logic rx_accept;
   logic tx_accept;

   assign itr_accept = itr_wr && itr_allowed && !itr_valid;
   assign rx_accept  = rx_wr && !rx_full;
   assign tx_accept  = tx_put && !tx_full;

   // instruction mailbox
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         itr_valid <= 1'b0;
         itr_word  <= '0;
      end else if (itr_accept) begin
         itr_valid <= 1'b1;
         itr_word  <= host_wdata;
      end else if (itr_ack) begin
         itr_valid <= 1'b0;
      end
   end

   // host-to-core mailbox
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_full <= 1'b0;
         rx_word <= '0;
      end else if (rx_accept) begin
         rx_full <= 1'b1;
         rx_word <= host_wdata;
      end else if (rx_take) begin
         rx_full <= 1'b0;
      end
   end

   // core-to-host mailbox
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_full <= 1'b0;
         tx_word <= '0;
      end else if (tx_accept) begin
         tx_full <= 1'b1;
         tx_word <= tx_data;
      end else if (tx_rd) begin
         tx_full <= 1'b0;
      end
   end

   AST_ITR_ONLY_ALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(itr_valid) |-> $past(itr_allowed)); // R8
   AST_ITR_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (itr_valid && !itr_ack) |=> (itr_valid && $stable(itr_word))); // R8
   AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && !rx_take) |=> (rx_full && $stable(rx_word))); // R9
   AST_TX_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && tx_rd) |=> !tx_full); // R10
endmodule

// File: rtl/dbg_run_ctl.sv
module dbg_run_ctl
   import dbg_run_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CAUSE_W     = 4,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               core_halted,
   input  logic [CAUSE_W-1:0] core_cause,
   input  logic               itr_ack,
   input  logic               rx_take,
   input  logic               tx_put,
   input  logic [DATA_W-1:0]  tx_data,
   output logic               halt_req,
   output logic               restart_req,
   output logic               hdbg_en,
   output logic               itr_valid,
   output logic [DATA_W-1:0]  itr_word,
   output logic               rx_full,
   output logic [DATA_W-1:0]  rx_word,
   output logic               tx_full
);
   localparam int unsigned CAUSE_HI = ST_CAUSE_LO + CAUSE_W - 1;

   initial begin
      assert (DATA_W >= 32);
      assert (ADDR_W == 8);
      assert (CAUSE_HI < ST_INSTR_EN);
   end

   reg_sel_e          sel;
   logic              locked;
   logic              wr_open;
   logic              instr_en;
   logic              halted;
   logic              restarted;
   logic [CAUSE_W-1:0] cause;
   logic [DATA_W-1:0] tx_word;
   logic [DATA_W-1:0] status_word;
   logic [DATA_W-1:0] read_mux;

   assign sel     = decode_ofs(bus_addr);
   assign wr_open = bus_wr && !locked;

   dbg_os_lock i_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_wr   (bus_wr && sel == SEL_LKACC),
      .acc_zero (bus_wdata == '0),
      .locked   (locked)
   );

   dbg_run_state #(
      .CAUSE_W     (CAUSE_W),
      .SYNC_STAGES (SYNC_STAGES),
      .HALT_CAUSE  ('0)
   ) i_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .halt_wr     (wr_open && sel == SEL_RUNCTL && bus_wdata[RC_HALT]),
      .restart_wr  (wr_open && sel == SEL_RUNCTL && bus_wdata[RC_RESTART]),
      .core_halted (core_halted),
      .core_cause  (core_cause),
      .halted      (halted),
      .restarted   (restarted),
      .cause       (cause),
      .halt_req    (halt_req),
      .restart_req (restart_req)
   );

   dbg_xfer #(.DATA_W(DATA_W)) i_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .itr_wr      (wr_open && sel == SEL_INSTR),
      .itr_allowed (halted && instr_en),
      .host_wdata  (bus_wdata),
      .itr_ack     (itr_ack),
      .rx_wr       (wr_open && sel == SEL_RXDATA),
      .rx_take     (rx_take),
      .tx_put      (tx_put),
      .tx_data     (tx_data),
      .tx_rd       (bus_rd && !locked && sel == SEL_TXDATA),
      .itr_valid   (itr_valid),
      .itr_word    (itr_word),
      .rx_full     (rx_full),
      .rx_word     (rx_word),
      .tx_full     (tx_full),
      .tx_word     (tx_word)
   );

   // writable control bits of the status word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         instr_en <= 1'b0;
         hdbg_en  <= 1'b0;
      end else if (wr_open && sel == SEL_STATUS) begin
         instr_en <= bus_wdata[ST_INSTR_EN];
         hdbg_en  <= bus_wdata[ST_HDBG_EN];
      end
   end

   always_comb begin
      status_word                       = '0;
      status_word[ST_HALTED]            = halted;
      status_word[ST_RESTARTED]         = restarted;
      status_word[CAUSE_HI:ST_CAUSE_LO] = cause;
      status_word[ST_INSTR_EN]          = instr_en;
      status_word[ST_HDBG_EN]           = hdbg_en;
      status_word[ST_INSTR_DONE]        = !itr_valid;
      status_word[ST_TX_FULL]           = tx_full;
      status_word[ST_RX_FULL]           = rx_full;
   end

   always_comb begin
      read_mux = '0;
      case (sel)
         SEL_STATUS:  read_mux = status_word;
         SEL_LKSTAT:  read_mux[LK_BIT_STAT] = locked;
         SEL_PWRSTAT: read_mux[LK_BIT_PWR]  = locked;
         SEL_TXDATA:  read_mux = tx_word;
         default:     read_mux = '0;
      endcase
      if (locked && sel != SEL_LKSTAT && sel != SEL_PWRSTAT)
         read_mux = '0;
   end

   assign bus_rdata = read_mux;

   AST_LOCKED_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && bus_wr && sel == SEL_STATUS) |=> $stable(hdbg_en)); // R3
   AST_LOCKED_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !halt_req) |=> !halt_req); // R3
   AST_LOCKED_NO_ITR: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !itr_valid) |=> !itr_valid); // R3
endmodule

// File: tb/test_dbg_run_ctl.sv
module test_dbg_run_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        core_halted = 1'b0;
   logic [3:0]  core_cause = '0;
   logic        itr_ack = 1'b0;
   logic        rx_take = 1'b0;
   logic        tx_put = 1'b0;
   logic [31:0] tx_data = '0;
   logic        halt_req, restart_req, hdbg_en, itr_valid, rx_full, tx_full;
   logic [31:0] itr_word, rx_word;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dbg_run_ctl i_dbg_run_ctl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_halted(core_halted), .core_cause(core_cause), .itr_ack(itr_ack),
      .rx_take(rx_take), .tx_put(tx_put), .tx_data(tx_data),
      .halt_req(halt_req), .restart_req(restart_req), .hdbg_en(hdbg_en),
      .itr_valid(itr_valid), .itr_word(itr_word), .rx_full(rx_full),
      .rx_word(rx_word), .tx_full(tx_full)
   );

   localparam logic [7:0] A_ST = 8'h00, A_RC = 8'h04, A_LA = 8'h08, A_LS = 8'h0C,
                          A_PW = 8'h10, A_IT = 8'h14, A_TX = 8'h18, A_RX = 8'h1C;

   // {write, addr, wdata, mask, expected, requirement}
   localparam int NV = 16;
   localparam logic [108:0] VEC [NV] = '{
      {1'b0, A_LS, 32'h0, 32'h0000_0002, 32'h0000_0002, 4'd2}, // R2 locked at reset
      {1'b0, A_PW, 32'h0, 32'h0000_0020, 32'h0000_0020, 4'd2}, // R2
      {1'b0, A_ST, 32'h0, 32'hFFFF_FFFF, 32'h0000_0000, 4'd3}, // R3 locked read zero
      {1'b1, A_ST, 32'h0000_6000, 32'h0, 32'h0, 4'd3},         // R3 ignored write
      {1'b1, A_LA, 32'h0, 32'h0, 32'h0, 4'd2},                 // R2 unlock
      {1'b0, A_LS, 32'h0, 32'h0000_0002, 32'h0000_0000, 4'd2}, // R2
      {1'b0, A_PW, 32'h0, 32'h0000_0020, 32'h0000_0000, 4'd2}, // R2
      {1'b0, A_ST, 32'h0, 32'hFFFF_FFFF, 32'h0100_0002, 4'd1}, // R1 status reset
      {1'b1, A_ST, 32'h0000_6000, 32'h0, 32'h0, 4'd7},         // R7
      {1'b0, A_ST, 32'h0, 32'h0000_6000, 32'h0000_6000, 4'd7}, // R7
      {1'b1, A_ST, 32'hFFFF_9FFF, 32'h0, 32'h0, 4'd7},         // R7 other bits ignored
      {1'b0, A_ST, 32'h0, 32'hFFFF_FFFF, 32'h0100_0002, 4'd7}, // R7
      {1'b1, A_LA, 32'h0000_0001, 32'h0, 32'h0, 4'd2},         // R2 relock
      {1'b0, A_LS, 32'h0, 32'h0000_0002, 32'h0000_0002, 4'd2}, // R2
      {1'b1, A_LA, 32'h0, 32'h0, 32'h0, 4'd2},                 // R2 unlock
      {1'b0, A_RC, 32'h0, 32'hFFFF_FFFF, 32'h0, 4'd6}          // R6 run control reads 0
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 outputs after reset
      chk("R1 outputs", {26'b0, halt_req, restart_req, itr_valid, rx_full, tx_full, hdbg_en}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v][108]) bus_write(VEC[v][107:100], VEC[v][99:68]);
         else begin
            bus_read(VEC[v][107:100], r);
            chk($sformatf("R%0d vector %0d", VEC[v][3:0], v), r & VEC[v][67:36], VEC[v][35:4]);
         end
      end

      // R8 instruction while running is ignored
      bus_write(A_ST, 32'h0000_6000);
      bus_write(A_IT, 32'hE1A0_000F);
      chk("R8 itr while running", {31'b0, itr_valid}, 32'h0);
      bus_read(A_ST, r);
      chk("R8 done bit while running", {31'b0, r[24]}, 32'h1);

      // R6 restart while running is ignored
      bus_write(A_RC, 32'h2);
      chk("R6 restart while running", {31'b0, restart_req}, 32'h0);
      bus_read(A_ST, r);
      chk("R6 restarted stays", {31'b0, r[1]}, 32'h1);

      // R4 halt request and R5 cause override
      core_cause = 4'b0001;
      bus_write(A_RC, 32'h1);
      chk("R4 halt_req raised", {31'b0, halt_req}, 32'h1);
      bus_read(A_ST, r);
      chk("R4 not yet halted", {31'b0, r[0]}, 32'h0);
      core_halted = 1'b1;
      idle(3);
      chk("R4 halt_req dropped", {31'b0, halt_req}, 32'h0);
      bus_read(A_ST, r);
      chk("R4 halted bit", {31'b0, r[0]}, 32'h1);
      chk("R5 cause halt request", {28'b0, r[5:2]}, 32'h0);
      chk("R7 hdbg_en pin", {31'b0, hdbg_en}, 32'h1);
      bus_write(A_RC, 32'h1);
      idle(1);
      chk("R4 halt while halted ignored", {31'b0, halt_req}, 32'h0);

      // R8 instruction mailbox
      bus_write(A_IT, 32'hE1A0_000F);
      chk("R8 itr_valid", {31'b0, itr_valid}, 32'h1);
      chk("R8 itr_word", itr_word, 32'hE1A0_000F);
      bus_read(A_ST, r);
      chk("R8 done low", {31'b0, r[24]}, 32'h0);
      bus_write(A_IT, 32'h1234_5678);
      chk("R8 busy write ignored", itr_word, 32'hE1A0_000F);
      pulse(itr_ack);
      bus_read(A_ST, r);
      chk("R8 done after ack", {30'b0, r[24], itr_valid}, 32'h2);
      bus_write(A_ST, 32'h0000_4000);
      bus_write(A_IT, 32'hEE00_0E15);
      chk("R8 disabled ignored", {31'b0, itr_valid}, 32'h0);

      // R9 host-to-core mailbox
      bus_write(A_RX, 32'h8000_0000);
      chk("R9 rx_full", {31'b0, rx_full}, 32'h1);
      bus_write(A_RX, 32'h0000_0011);
      chk("R9 full write ignored", rx_word, 32'h8000_0000);
      bus_read(A_ST, r);
      chk("R9 status bit30", {31'b0, r[30]}, 32'h1);
      pulse(rx_take);
      chk("R9 take empties", {31'b0, rx_full}, 32'h0);

      // R10 core-to-host mailbox
      tx_data = 32'h8000_0008; pulse(tx_put);
      tx_data = 32'hDEAD_BEEF; pulse(tx_put);
      bus_read(A_ST, r);
      chk("R10 status bit29", {31'b0, r[29]}, 32'h1);
      bus_read(A_TX, r);
      chk("R10 first word kept", r, 32'h8000_0008);
      chk("R10 read empties", {31'b0, tx_full}, 32'h0);

      // R3 locked read of core-to-host data
      tx_data = 32'hCAFE_0001; pulse(tx_put);
      bus_write(A_LA, 32'h1);
      bus_read(A_TX, r);
      chk("R3 locked read zero", r, 32'h0);
      chk("R3 locked read keeps full", {31'b0, tx_full}, 32'h1);
      bus_write(A_RC, 32'h2);
      chk("R3 locked restart ignored", {31'b0, restart_req}, 32'h0);
      bus_write(A_LA, 32'h0);
      bus_read(A_TX, r);
      chk("R10 word after unlock", r, 32'hCAFE_0001);

      // R6 restart handshake
      bus_write(A_RC, 32'h2);
      chk("R6 restart_req", {31'b0, restart_req}, 32'h1);
      bus_read(A_ST, r);
      chk("R6 restarted cleared", {31'b0, r[1]}, 32'h0);
      core_halted = 1'b0;
      idle(3);
      chk("R6 restart_req dropped", {31'b0, restart_req}, 32'h0);
      bus_read(A_ST, r);
      chk("R6 restarted and running", {30'b0, r[1:0]}, 32'h2);

      // R5 breakpoint then watchpoint entry by the core
      core_cause = 4'b0001; core_halted = 1'b1;
      idle(3);
      bus_read(A_ST, r);
      chk("R5 breakpoint cause", {28'b0, r[5:2]}, 32'h1);
      bus_write(A_RC, 32'h2);
      core_halted = 1'b0;
      idle(3);
      core_cause = 4'b1010; core_halted = 1'b1;
      idle(3);
      bus_read(A_ST, r);
      chk("R5 watchpoint cause", {28'b0, r[5:2]}, 32'hA);

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule